// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Pin Controller

This block controls 94 general-purpose pins through a plain 32-bit register read/write port. Every pin has two configuration words of its own. With them, software decides whether the pad is driven by the pin logic or left to a native function, whether it is an output or an input, what level it drives, and how it raises an interrupt. The weak pull choice for each pin is also held there. Three kinds of one-bit-per-pin bitmap registers are shared across pins, each spread over three 32-bit words: a firmware ownership map, interrupt status, and interrupt enable. A single global control word is stored for the interrupt line selection.

Each pad input passes through a two-flop synchroniser. The synchronised level is then offered to the readback field and to an edge or level detector. Status bits are cleared by writing ones. The enabled status bits are merged into one interrupt output.

Software uses the block in a fixed order. Firmware first marks the pins it keeps reserved. The driver then sets up the remaining pins, enables their interrupts, and services the combined output by reading and clearing the status words.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset the following values hold. Every first config word reads 0x00000004 (input, native function). Every second config word reads 0. Status and enable words read 0. The ownership words read 0xFFFFFFFF, 0xFFFFFFFF and 0x3FFFFFFF. irqOut is 0 and padOe is all zero.
- R2: For each of the ownership (0x00), status (0x80) and enable (0x90) maps, pin n sits in the word at base+(n/32)*4, at bit n mod 32. Bits for pins 94 and above read 0 and are not writable.
- R3: The first config word of pin n is at 0x100+8n and the second is at 0x104+8n. The first word has these fields: bit 31 output level, bit 30 sampled input (read-only), bit 4 trigger type (1 level, 0 edge), bit 3 sense inversion, bit 2 direction (1 input), bit 0 use-select (1 pin logic). Undefined bits read 0.
- R4: padOut[n] follows the output level bit. padOe[n] is 1 exactly when use-select is 1 and direction is 0.
- R5: Bit 30 reads the pad level two clocks after it settles. It reads 0 while bit 2 of the second config word (sense disable) is set.
- R6: In edge mode, the status bit is set on a rising synchronised input. With inversion it is set on a falling input instead, and the opposite transition leaves it alone.
- R7: In level mode, the status bit stays set while the input is at the active level (high, or low when inverted). Clearing it while the level is active leaves it set.
- R8: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged.
- R9: irqOut is the OR over all pins of status AND enable.
- R10: While sense disable is set, the pin sets no status bit.
- R11: While a pin's ownership bit is 0 (firmware reserved), writes to both of its config words are ignored.
- R12: Offset 0x7C holds a 32-bit read/write global control word. Reads of unmapped or non-word-aligned offsets return 0. Read data arrives one clock after regRdEn and is 0 on cycles without a read.
- R13: Bits 1:0 of the second config word store the pull option. They are driven on padPull[2n+1:2n] and read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 12 | Byte address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, one clock after regRdEn |
| padIn | input | 94 | Pad input levels |
| padOut | output | 94 | Pad output levels |
| padOe | output | 94 | Pad output enables |
| padPull | output | 188 | Two pull-option bits per pin |
| irqOut | output | 1 | Combined interrupt |

## Verification
Interrupt detection is driven with four input patterns, each telling a different detector fault apart from the correct behaviour:
- A plain rising then falling edge on an edge-mode pin separates a true edge detector from one that triggers on both transitions.
- An inverted edge-mode pin, driven up then down, shows whether the inversion swaps the active transition.
- A level-mode pin held high during a clear tells level from edge behaviour, because the status bit must come straight back.
- A pin with sensing disabled must stay silent and read 0, which separates gating of detection from gating of readback alone.

Register map behaviour is probed with all-ones and junk writes to the last bitmap word, to config fields and to reserved pins. This exposes bits that are wrongly stored, positions that are misplaced, and ownership that is ignored.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_OWN,
    SEL_GLOB,
    SEL_STAT,
    SEL_EN,
    SEL_CFG1,
    SEL_CFG2
  } regSel_e;

  // Strobes passed from the decoder to the datapath
  typedef struct packed {
    logic    wr;
    logic    rd;
    regSel_e sel;
    logic [7:0] pinIdx;
    logic [2:0] wordIdx;
  } busStrobe_t;

  localparam int OWN_BASE  = 'h000;
  localparam int GLOB_ADDR = 'h07C;
  localparam int STAT_BASE = 'h080;
  localparam int EN_BASE   = 'h090;
  localparam int CFG_BASE  = 'h100;

endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 94,
  parameter int ADDR_W   = 12
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output busStrobe_t        strb
);

  localparam int NUM_WORDS = (NUM_PINS + 31) / 32;
  localparam logic [ADDR_W-1:0] OWN_A   = ADDR_W'(OWN_BASE);
  localparam logic [ADDR_W-1:0] GLOB_A  = ADDR_W'(GLOB_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A  = ADDR_W'(STAT_BASE);
  localparam logic [ADDR_W-1:0] EN_A    = ADDR_W'(EN_BASE);
  localparam logic [ADDR_W-1:0] CFG_A   = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] MAP_LEN = ADDR_W'(4 * NUM_WORDS);
  localparam logic [ADDR_W-4:0] PIN_LIM = (ADDR_W-3)'(NUM_PINS);

  logic [ADDR_W-1:0] ownRel, statRel, enRel, cfgRel;

  always_comb begin
    ownRel  = regAddr - OWN_A;
    statRel = regAddr - STAT_A;
    enRel   = regAddr - EN_A;
    cfgRel  = regAddr - CFG_A;

    strb         = '0;
    strb.wr      = regWrEn;
    strb.rd      = regRdEn;
    strb.sel     = SEL_NONE;

    if (regAddr[1:0] == 2'b00) begin
      if (regAddr == GLOB_A) begin
        strb.sel = SEL_GLOB;
      end else if (regAddr >= OWN_A && ownRel < MAP_LEN) begin
        strb.sel     = SEL_OWN;
        strb.wordIdx = ownRel[4:2];
      end else if (regAddr >= STAT_A && statRel < MAP_LEN) begin
        strb.sel     = SEL_STAT;
        strb.wordIdx = statRel[4:2];
      end else if (regAddr >= EN_A && enRel < MAP_LEN) begin
        strb.sel     = SEL_EN;
        strb.wordIdx = enRel[4:2];
      end else if (regAddr >= CFG_A && cfgRel[ADDR_W-1:3] < PIN_LIM) begin
        strb.sel    = cfgRel[2] ? SEL_CFG2 : SEL_CFG1;
        strb.pinIdx = 8'(cfgRel[ADDR_W-1:3]);
      end
    end
  end

endmodule

// File: rtl/gpio_bank_core.sv
module gpio_bank_core
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 94
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  busStrobe_t            strb,
  input  logic [31:0]           wrData,
  input  logic [NUM_PINS-1:0]   padIn,
  output logic [31:0]           rdData,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   padOe,
  output logic [2*NUM_PINS-1:0] padPull,
  output logic                  irqOut
);

  localparam int NUM_WORDS = (NUM_PINS + 31) / 32;
  localparam int PAD_BITS  = NUM_WORDS * 32;

  // Per-pin configuration state
  logic [NUM_PINS-1:0]   owned, statBits, irqEn;
  logic [NUM_PINS-1:0]   outLvl, trigLvl, invSense, dirIn, useGpio, senseOff;
  logic [2*NUM_PINS-1:0] pullSel;
  logic [NUM_PINS-1:0]   syncA, syncB, syncPrev;
  logic [31:0]           globCtl;

  logic [NUM_PINS-1:0] sensed, effNow, effOld, setNow, clrNow;

  logic wrOwn, wrStat, wrEn, wrCfg1, wrCfg2, wrGlob;

  assign wrOwn  = strb.wr && strb.sel == SEL_OWN;
  assign wrStat = strb.wr && strb.sel == SEL_STAT;
  assign wrEn   = strb.wr && strb.sel == SEL_EN;
  assign wrCfg1 = strb.wr && strb.sel == SEL_CFG1;
  assign wrCfg2 = strb.wr && strb.sel == SEL_CFG2;
  assign wrGlob = strb.wr && strb.sel == SEL_GLOB;

  // Detection, one slice per pin
  logic [31:0] cfg1Word [NUM_PINS];
  logic [31:0] cfg2Word [NUM_PINS];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign sensed[p] = syncB[p] & ~senseOff[p];
    assign effNow[p] = syncB[p] ^ invSense[p];
    assign effOld[p] = syncPrev[p] ^ invSense[p];
    assign setNow[p] = ~senseOff[p] &
                       (trigLvl[p] ? effNow[p] : (effNow[p] & ~effOld[p]));
    assign clrNow[p] = wrStat && strb.wordIdx == 3'(p / 32) && wrData[p % 32];
    assign cfg1Word[p] = {outLvl[p], sensed[p], 25'd0, trigLvl[p],
                          invSense[p], dirIn[p], 1'b0, useGpio[p]};
    assign cfg2Word[p] = {29'd0, senseOff[p], pullSel[2*p+1], pullSel[2*p]};
  end

  // Bitmaps reshaped into words, upper bits padded with zero
  logic [PAD_BITS-1:0] ownPad, statPad, enPad;
  logic [31:0] ownArr [NUM_WORDS];
  logic [31:0] statArr[NUM_WORDS];
  logic [31:0] enArr  [NUM_WORDS];

  assign ownPad  = PAD_BITS'(owned);
  assign statPad = PAD_BITS'(statBits);
  assign enPad   = PAD_BITS'(irqEn);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign ownArr[w]  = ownPad[w*32 +: 32];
    assign statArr[w] = statPad[w*32 +: 32];
    assign enArr[w]   = enPad[w*32 +: 32];
  end

  // Sequential state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      owned    <= '1;
      statBits <= '0;
      irqEn    <= '0;
      outLvl   <= '0;
      trigLvl  <= '0;
      invSense <= '0;
      dirIn    <= '1;
      useGpio  <= '0;
      senseOff <= '0;
      pullSel  <= '0;
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
      globCtl  <= '0;
    end else begin
      syncA    <= padIn;
      syncB    <= syncA;
      syncPrev <= syncB;
      statBits <= (statBits & ~clrNow) | setNow;
      if (wrGlob) globCtl <= wrData;
      for (int i = 0; i < NUM_PINS; i++) begin
        if (strb.wordIdx == 3'(i / 32)) begin
          if (wrOwn) owned[i] <= wrData[i % 32];
          if (wrEn)  irqEn[i] <= wrData[i % 32];
        end
        if (strb.pinIdx == 8'(i) && owned[i]) begin
          if (wrCfg1) begin
            outLvl[i]   <= wrData[31];
            trigLvl[i]  <= wrData[4];
            invSense[i] <= wrData[3];
            dirIn[i]    <= wrData[2];
            useGpio[i]  <= wrData[0];
          end
          if (wrCfg2) begin
            senseOff[i]    <= wrData[2];
            pullSel[2*i]   <= wrData[0];
            pullSel[2*i+1] <= wrData[1];
          end
        end
      end
    end
  end

  // Read selection
  logic [31:0] rdWord;

  always_comb begin
    rdWord = '0;
    unique case (strb.sel)
      SEL_GLOB: rdWord = globCtl;
      SEL_OWN, SEL_STAT, SEL_EN: begin
        for (int w = 0; w < NUM_WORDS; w++) begin
          if (strb.wordIdx == 3'(w)) begin
            if (strb.sel == SEL_OWN)       rdWord = ownArr[w];
            else if (strb.sel == SEL_STAT) rdWord = statArr[w];
            else                           rdWord = enArr[w];
          end
        end
      end
      SEL_CFG1, SEL_CFG2: begin
        for (int i = 0; i < NUM_PINS; i++) begin
          if (strb.pinIdx == 8'(i)) begin
            rdWord = (strb.sel == SEL_CFG1) ? cfg1Word[i] : cfg2Word[i];
          end
        end
      end
      default: rdWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        rdData <= '0;
    else if (strb.rd) rdData <= rdWord;
    else              rdData <= '0;
  end

  assign padOut  = outLvl;
  assign padOe   = useGpio & ~dirIn;
  assign padPull = pullSel;
  assign irqOut  = |(statBits & irqEn);

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 94,
  parameter int ADDR_W   = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [31:0]           regWrData,
  output logic [31:0]           regRdData,
  input  logic [NUM_PINS-1:0]   padIn,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   padOe,
  output logic [2*NUM_PINS-1:0] padPull,
  output logic                  irqOut
);

  busStrobe_t strb;

  gpio_bank_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_decode (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  gpio_bank_core #(.NUM_PINS(NUM_PINS)) u_core (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (regWrData),
    .padIn   (padIn),
    .rdData  (regRdData),
    .padOut  (padOut),
    .padOe   (padOe),
    .padPull (padPull),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NUM_PINS = 94
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  regWrEn,
  input logic                  regRdEn,
  input logic [31:0]           regRdData,
  input logic [NUM_PINS-1:0]   padOe,
  input logic [2*NUM_PINS-1:0] padPull,
  input logic                  irqOut
);

  // R1: quiet outputs on leaving reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!irqOut && padOe == '0));

  // R12: read data is zero when no read was issued
  p_rd_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regRdEn) |-> regRdData == '0);

  // R4: drive enables move only after a register write
  p_oe_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regWrEn) |-> $stable(padOe));

  // R13: pull outputs move only after a register write
  p_pull_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regWrEn) |-> $stable(padPull));

endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regRdEn   (regRdEn),
  .regRdData (regRdData),
  .padOe     (padOe),
  .padPull   (padPull),
  .irqOut    (irqOut)
);

// File: tb/test_gpio_bank_ctrl.sv
module test_gpio_bank_ctrl;

  localparam int N = 94;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic          regRdEn = 1'b0;
  logic [11:0]   regAddr = '0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic [N-1:0]  padIn = '0;
  logic [N-1:0]  padOut, padOe;
  logic [2*N-1:0] padPull;
  logic          irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  gpio_bank_ctrl i_gpio_bank_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .padPull(padPull),
    .irqOut(irqOut)
  );

  // Scoreboard queues
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdSeen = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rdSeen <= regRdEn;

  // Monitor: compare read data the cycle after the read strobe
  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) check("RDQ", 32'd1, 32'd0);
      else check(tagQ.pop_front(), regRdData, expQ.pop_front());
    end
  end

  task automatic wrReg(int addr, logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 12'(addr); regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(int addr, logic [31:0] exp, string tag);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = 12'(addr);
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic int c1(int p); return 'h100 + 8*p; endfunction
  function automatic int c2(int p); return 'h104 + 8*p; endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state
    check("R1 irq", {31'd0, irqOut}, 32'd0);
    check("R1 oe", {31'd0, |padOe}, 32'd0);
    rdChk(c1(0), 32'h4, "R1 cfg1");
    rdChk(c2(93), 32'h0, "R1 cfg2");
    rdChk('h00, 32'hFFFFFFFF, "R1 own0");
    rdChk('h04, 32'hFFFFFFFF, "R1 own1");
    rdChk('h08, 32'h3FFFFFFF, "R1 own2");
    rdChk('h80, 32'h0, "R1 stat0");
    rdChk('h98, 32'h0, "R1 en2");

    // Config fields and pad drive, pin 33
    wrReg(c1(33), 32'hFFFFFFFF);
    rdChk(c1(33), 32'h8000001D, "R3 fields");
    wrReg(c1(33), 32'h80000001);
    rdChk(c1(33), 32'h80000001, "R3 readback");
    @(negedge clk);
    check("R4 oe", {31'd0, padOe == (N'(1) << 33)}, 32'd1);
    check("R4 out", {31'd0, padOut[33]}, 32'd1);

    // Firmware-reserved pin ignores config writes
    wrReg('h04, 32'hFFFFFFFD);
    wrReg(c1(33), 32'h00000004);
    wrReg(c2(33), 32'h00000003);
    rdChk(c1(33), 32'h80000001, "R11 cfg1 locked");
    rdChk(c2(33), 32'h0, "R11 cfg2 locked");
    check("R11 oe kept", {31'd0, padOe[33]}, 32'd1);
    wrReg('h04, 32'hFFFFFFFF);

    // Global word and unmapped offsets
    wrReg('h7C, 32'hDEADBEEF);
    rdChk('h7C, 32'hDEADBEEF, "R12 glob");
    rdChk('h40, 32'h0, "R12 hole");
    rdChk('h3F0, 32'h0, "R12 past cfg");
    rdChk('h102, 32'h0, "R12 unaligned");

    // Input sampling and edge detection, pin 0
    padIn[0] = 1'b1;
    settle();
    rdChk(c1(0), 32'h40000004, "R5 sample");
    rdChk('h80, 32'h1, "R6 rise sets");
    wrReg(c2(0), 32'h4);
    rdChk(c1(0), 32'h4, "R5 sense off");
    wrReg(c2(0), 32'h0);
    wrReg('h80, 32'h0);
    rdChk('h80, 32'h1, "R8 zero write");
    wrReg('h80, 32'h1);
    rdChk('h80, 32'h0, "R8 clear");
    wrReg('h90, 32'h1);
    rdChk('h90, 32'h1, "R2 en0");
    check("R9 no status", {31'd0, irqOut}, 32'd0);
    padIn[0] = 1'b0;
    settle();
    rdChk('h80, 32'h0, "R6 fall ignored");
    padIn[0] = 1'b1;
    settle();
    check("R9 irq", {31'd0, irqOut}, 32'd1);
    wrReg('h80, 32'h1);
    check("R9 irq cleared", {31'd0, irqOut}, 32'd0);
    wrReg('h90, 32'h0);

    // Inverted edge, pin 93 (word 2 bit 29)
    wrReg(c1(93), 32'hC);
    padIn[93] = 1'b1;
    settle();
    rdChk('h88, 32'h0, "R6 inv rise ignored");
    padIn[93] = 1'b0;
    settle();
    rdChk('h88, 32'h20000000, "R6 inv fall sets");
    wrReg('h88, 32'h20000000);

    // Level mode, pin 1
    wrReg(c1(1), 32'h14);
    padIn[1] = 1'b1;
    settle();
    rdChk('h80, 32'h2, "R7 level set");
    wrReg('h80, 32'h2);
    rdChk('h80, 32'h2, "R7 level reasserts");
    padIn[1] = 1'b0;
    settle();
    wrReg('h80, 32'h2);
    rdChk('h80, 32'h0, "R7 level gone");

    // Sense disabled, pin 2
    wrReg(c2(2), 32'h4);
    padIn[2] = 1'b1;
    settle();
    rdChk('h80, 32'h0, "R10 no status");
    rdChk(c1(2), 32'h4, "R10 reads zero");
    wrReg(c2(2), 32'h6);
    rdChk(c2(2), 32'h6, "R13 pull readback");
    check("R13 pad pull", {30'd0, padPull[5:4]}, 32'd2);

    // Last bitmap word upper bits
    wrReg('h08, 32'hC0000000);
    rdChk('h08, 32'h0, "R2 own2 upper");
    wrReg('h08, 32'hFFFFFFFF);
    rdChk('h08, 32'h3FFFFFFF, "R2 own2 mask");
    wrReg('h98, 32'hFFFFFFFF);
    rdChk('h98, 32'h3FFFFFFF, "R2 en2 mask");
    wrReg('h98, 32'h0);

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) check("RDQ drain", 32'(expQ.size()), 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule